// File: doc/BRIEF.md
# Bit-Reversal Symbol Interleaver with Sync Merge

This block takes a serial stream of coded bits and scatters them into a frame of 162 two-bit channel symbols. An 8-bit counter walks upward from zero; each counter value is bit-reversed, and reversed values of 162 or more are skipped. Each accepted input bit is written to the position given by the next reversed value that is in range. Each stored position is then combined with a fixed sync bit taken from a 162-bit constant. The result is a four-level symbol: the sync bit is the low bit and the data bit is the high bit.

A producer offers bits with a valid/ready handshake. The block lowers ready on the cycles where it is stepping past out-of-range reversed values. Once all 162 positions are written, the frame-full flag rises and stays high. From then on a consumer reads symbols in position order, 0 to 161, moving one position per read strobe. A start pulse begins a new frame.

Top module: `symbol_interleaver`

## Requirements
- R1: After synchronous active-low reset, `frame_full_o` is 0, `bit_ready_o` is 1 and `sym_o` is 0.
- R2: Input bit number i (counting from 0 after reset or start) is stored at position p(i). Take the 8-bit counter values k in ascending order and form rev(k), where bit b of k becomes bit 7-b. p(i) is the i-th of those rev(k) values that is below 162.
- R3: While full, `sym_o` at position p equals sync(p) + 2*data(p): bit 0 is the sync bit and bit 1 is the data bit.
- R4: The sync bits are a fixed 162-bit pattern. Positions 0 to 15 hold 1,1,0,0,0,0,0,0,1,0,0,0,1,1,1,0, in that order.
- R5: The counter steps once per cycle past out-of-range values, with `bit_ready_o` low on those cycles. With valid held high from a start pulse, the frame fills in exactly 255 cycles.
- R6: Once full, `bit_ready_o` stays low and further input bits change no stored symbol.
- R7: While full, `sym_o` shows the symbol at the read position, which starts at 0. Each `rd_strobe_i` advances it by one, and 161 wraps to 0. While not full, `sym_o` is 0.
- R8: A start pulse clears the write count, the bit counter and the read position, so a partly written frame is discarded. Start takes priority over a write in the same cycle.
- R9: Cycles with `bit_valid_i` low stall the counter at an in-range value, so gaps in the input do not change the mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a new frame |
| bit_valid_i | input | 1 | Input coded bit is valid |
| bit_i | input | 1 | Input coded bit |
| bit_ready_o | output | 1 | Block accepts the offered bit this cycle |
| frame_full_o | output | 1 | All 162 positions written |
| rd_strobe_i | input | 1 | Advance the read position |
| sym_o | output | 2 | Symbol at the read position (0 while not full) |

## Verification
The bench fills frames of all zeros, all ones, and random bits with random gaps. It compares every read symbol against a permutation and sync model it builds itself. If the bit reversal or the skip rule is wrong, random data lands at the wrong positions. If the fields are swapped or the sync constant is wrong, the all-zero and all-one frames show it directly. The fill time is counted against 255 cycles, which exposes a counter that stalls on skipped values or runs past the last slot. Three more cases are aimed at control errors: bits offered after the frame is full (they must leave the contents unchanged), a start pulse in the middle of filling or reading, and a read position that must wrap to 0 after 161.

// File: rtl/ilv_pkg.sv
// Shared constants for the symbol interleaver.
// Assumes a 162-symbol frame addressed by 8-bit indices.
package ilv_pkg;
    localparam int IDX_W = 8;
    localparam int N_SYM = 162;
    localparam int CNT_W = $clog2(N_SYM + 1);
    // Sync pattern; the most significant bit is position 0.
    localparam logic [N_SYM-1:0] SYNC_PAT =
        {160'hC08E25E0_2502CD1A_1AA92C6A_2093B347_05301AC6, 2'b00};
endpackage

// File: rtl/ilv_addr_gen.sv
// Address generator: an up-counter whose bit-reversed value is the write
// position. Flags when that reversed value falls inside the frame.
// Assumes the controller steps it only while a frame is being filled.
module ilv_addr_gen #(
    parameter int IDX_W = ilv_pkg::IDX_W,
    parameter int N_SYM = ilv_pkg::N_SYM
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] pos_o,
    output logic             slot_ok_o
);
    logic [IDX_W-1:0] k_q;
    logic [IDX_W-1:0] rev;

    // Counter: cleared by reset or start, stepped on request.
    always_ff @(posedge clk) begin
        if (!rst_n)       k_q <= '0;
        else if (clear_i) k_q <= '0;
        else if (step_i)  k_q <= k_q + 1'b1;
    end

    // Bit reversal of the counter.
    for (genvar b = 0; b < IDX_W; b++) begin : g_rev
        assign rev[b] = k_q[IDX_W-1-b];
    end

    assign pos_o     = rev;
    assign slot_ok_o = (int'(rev) < N_SYM);

    // R5: the counter never steps past the all-ones value while filling.
    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clear_i) |=> (k_q != '0));
endmodule

// File: rtl/ilv_sym_buf.sv
// One-bit-per-position data store, written at scattered positions and
// read at the read position; merges the sync bit into the symbol.
// Assumes write positions are always inside the frame.
module ilv_sym_buf #(
    parameter int IDX_W = ilv_pkg::IDX_W,
    parameter int N_SYM = ilv_pkg::N_SYM,
    parameter logic [N_SYM-1:0] SYNC = ilv_pkg::SYNC_PAT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [IDX_W-1:0] waddr_i,
    input  logic             wbit_i,
    input  logic [IDX_W-1:0] raddr_i,
    output logic [1:0]       sym_o
);
    logic [N_SYM-1:0] mem_q;
    logic             sync_bit;

    // Storage: write one data bit per accepted input.
    always_ff @(posedge clk) begin
        if (we_i) mem_q[waddr_i] <= wbit_i;
    end

    // Merge: data bit on top, sync bit below.
    always_comb begin
        sync_bit = SYNC[N_SYM-1-int'(raddr_i)];
        sym_o    = {mem_q[raddr_i], sync_bit};
    end

    // R2: every write lands inside the frame.
    p_waddr_in_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (int'(waddr_i) < N_SYM));
    // R7: reads stay inside the frame.
    p_raddr_in_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int'(raddr_i) < N_SYM);
endmodule

// File: rtl/symbol_interleaver.sv
// Top: accepts coded bits with a valid/ready handshake, scatters them to
// bit-reversed positions, and reads merged symbols out in order once full.
// Assumes start_i is a single-cycle pulse; reset is synchronous active-low.
module symbol_interleaver #(
    parameter int IDX_W = ilv_pkg::IDX_W,
    parameter int N_SYM = ilv_pkg::N_SYM,
    parameter logic [N_SYM-1:0] SYNC = ilv_pkg::SYNC_PAT
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       bit_valid_i,
    input  logic       bit_i,
    output logic       bit_ready_o,
    output logic       frame_full_o,
    input  logic       rd_strobe_i,
    output logic [1:0] sym_o
);
    localparam int CNT_W = $clog2(N_SYM + 1);

    logic [CNT_W-1:0] wr_cnt_q;
    logic [IDX_W-1:0] rd_ptr_q;
    logic [IDX_W-1:0] wr_pos;
    logic             slot_ok;
    logic             full;
    logic             accept;
    logic             step;
    logic [1:0]       buf_sym;

    assign full         = (wr_cnt_q == CNT_W'(N_SYM));
    assign bit_ready_o  = !full && slot_ok;
    assign accept       = bit_valid_i && bit_ready_o && !start_i;
    assign step         = !full && (accept || !slot_ok);
    assign frame_full_o = full;
    assign sym_o        = full ? buf_sym : 2'b00;

    ilv_addr_gen #(.IDX_W(IDX_W), .N_SYM(N_SYM)) addr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (start_i),
        .step_i   (step),
        .pos_o    (wr_pos),
        .slot_ok_o(slot_ok)
    );

    ilv_sym_buf #(.IDX_W(IDX_W), .N_SYM(N_SYM), .SYNC(SYNC)) buf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (accept),
        .waddr_i(wr_pos),
        .wbit_i (bit_i),
        .raddr_i(rd_ptr_q),
        .sym_o  (buf_sym)
    );

    // Write count: number of positions filled in the current frame.
    always_ff @(posedge clk) begin
        if (!rst_n)       wr_cnt_q <= '0;
        else if (start_i) wr_cnt_q <= '0;
        else if (accept)  wr_cnt_q <= wr_cnt_q + 1'b1;
    end

    // Read position: advances per strobe while full, wrapping at the end.
    always_ff @(posedge clk) begin
        if (!rst_n)       rd_ptr_q <= '0;
        else if (start_i) rd_ptr_q <= '0;
        else if (full && rd_strobe_i)
            rd_ptr_q <= (rd_ptr_q == IDX_W'(N_SYM-1)) ? '0 : rd_ptr_q + 1'b1;
    end

    // R6: no bit is taken once the frame is full.
    p_full_no_ready_r6: assert property (@(posedge clk) disable iff (!rst_n)
        frame_full_o |-> !bit_ready_o);
    // R6: full persists until the next start.
    p_full_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_full_o && !start_i) |=> frame_full_o);
    // R7: no symbol is shown before the frame is full.
    p_sym_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_full_o |-> (sym_o == 2'b00));
    // R7: the read position moves only on a strobe.
    p_rd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_strobe_i && !start_i) |=> $stable(rd_ptr_q));
    // R8: start empties the frame.
    p_start_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!frame_full_o && wr_cnt_q == '0 && rd_ptr_q == '0));
    // R2: the write count never exceeds the frame size.
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        int'(wr_cnt_q) <= N_SYM);
endmodule

// File: tb/symbol_interleaver_tb.sv
`timescale 1ns/1ps
module symbol_interleaver_tb_top;
    localparam int N = 162;
    localparam logic [N-1:0] SYNC_REF =
        {160'hC08E25E0_2502CD1A_1AA92C6A_2093B347_05301AC6, 2'b00};
    localparam logic [15:0] SYNC_HEAD = 16'b1100_0000_1000_1110;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic bit_valid = 1'b0;
    logic bit_in = 1'b0;
    logic rd_strobe = 1'b0;
    logic bit_ready;
    logic full;
    logic [1:0] sym;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;
    int perm [N];
    bit frame_bits [N];
    logic [1:0] exp_sym [N];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    symbol_interleaver dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .bit_valid_i(bit_valid),
        .bit_i(bit_in), .bit_ready_o(bit_ready), .frame_full_o(full),
        .rd_strobe_i(rd_strobe), .sym_o(sym)
    );

    function automatic int rev8(input int k);
        int r = 0;
        for (int b = 0; b < 8; b++) r = (r << 1) | ((k >> b) & 1);
        return r;
    endfunction

    function automatic bit sync_ref(input int j);
        return SYNC_REF[N-1-j];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic build_expect();
        for (int i = 0; i < N; i++)
            exp_sym[perm[i]] = {frame_bits[i], sync_ref(perm[i])};
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic fill_frame(input bit gaps, input int count);
        for (int i = 0; i < count; i++) begin
            if (gaps && ($urandom % 4 == 0)) begin
                bit_valid = 1'b0;
                repeat ($urandom % 3 + 1) @(negedge clk);
            end
            bit_valid = 1'b1;
            bit_in = frame_bits[i];
            while (!bit_ready) @(negedge clk);
            @(negedge clk);
        end
        bit_valid = 1'b0;
    endtask

    task automatic read_frame(input string tag);
        for (int j = 0; j < N; j++) begin
            chk(sym === exp_sym[j], tag, int'(sym), int'(exp_sym[j]));
            if (j < 16)
                chk(sym[0] === SYNC_HEAD[15-j], "R4 sync head", int'(sym[0]), int'(SYNC_HEAD[15-j]));
            rd_strobe = 1'b1;
            @(negedge clk);
        end
        rd_strobe = 1'b0;
        chk(sym === exp_sym[0], "R7 wrap to position 0", int'(sym), int'(exp_sym[0]));
    endtask

    initial begin
        while (!done && cyc < 200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 200000);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int c0;
        int last_k;
        int idx;
        void'($urandom(32'h5EED_1234));
        idx = 0;
        last_k = 0;
        for (int k = 0; k < 256; k++)
            if (rev8(k) < N) begin perm[idx] = rev8(k); idx++; last_k = k; end

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        chk(full === 1'b0, "R1 full after reset", int'(full), 0);
        chk(bit_ready === 1'b1, "R1 ready after reset", int'(bit_ready), 1);
        chk(sym === 2'b00, "R1 symbol after reset", int'(sym), 0);

        // All-zero frame, continuous valid, timed (R5, R3)
        for (int i = 0; i < N; i++) frame_bits[i] = 1'b0;
        build_expect();
        pulse_start();
        c0 = cyc;
        fill_frame(1'b0, N);
        chk((cyc - c0) == last_k + 1, "R5 fill cycles", cyc - c0, last_k + 1);
        chk(full === 1'b1, "R5 full after fill", int'(full), 1);
        read_frame("R3 zero frame");

        // All-one frame (R3)
        for (int i = 0; i < N; i++) frame_bits[i] = 1'b1;
        build_expect();
        pulse_start();
        fill_frame(1'b0, N);
        read_frame("R3 one frame");

        // Random data with gaps (R2, R9), then extra bits ignored (R6)
        for (int i = 0; i < N; i++) frame_bits[i] = 1'($urandom);
        build_expect();
        pulse_start();
        fill_frame(1'b1, N);
        chk(full === 1'b1, "R9 full after gapped fill", int'(full), 1);
        read_frame("R2 R9 random gapped frame");
        bit_valid = 1'b1;
        for (int t = 0; t < 20; t++) begin
            bit_in = ~exp_sym[t][1];
            chk(bit_ready === 1'b0, "R6 ready low when full", int'(bit_ready), 0);
            @(negedge clk);
        end
        bit_valid = 1'b0;
        read_frame("R6 contents kept after extra bits");

        // Partial frame discarded by start (R8)
        for (int i = 0; i < N; i++) frame_bits[i] = 1'($urandom);
        fill_frame(1'b0, 0);
        pulse_start();
        fill_frame(1'b1, 50);
        chk(full === 1'b0, "R8 not full mid frame", int'(full), 0);
        bit_valid = 1'b1;
        bit_in = 1'b1;
        pulse_start();
        bit_valid = 1'b0;
        chk(bit_ready === 1'b1, "R8 counter back at zero", int'(bit_ready), 1);
        chk(full === 1'b0, "R8 cleared by start", int'(full), 0);
        for (int i = 0; i < N; i++) frame_bits[i] = 1'($urandom);
        build_expect();
        fill_frame(1'b1, N);
        read_frame("R8 frame after restart");

        // Start during readout resets read position (R7, R8)
        rd_strobe = 1'b1;
        repeat (10) @(negedge clk);
        rd_strobe = 1'b0;
        chk(sym === exp_sym[10], "R7 read position after 10 strobes", int'(sym), int'(exp_sym[10]));
        for (int i = 0; i < N; i++) frame_bits[i] = 1'($urandom);
        build_expect();
        pulse_start();
        chk(sym === 2'b00, "R7 symbol idle while filling", int'(sym), 0);
        fill_frame(1'b1, N);
        read_frame("R8 read position reset");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule